// File: doc/BRIEF.md
# Packet-Aware FIFO Level Flag

This block produces a single programmable-level status flag for one endpoint buffer that holds data as packets. It keeps three counts of its own, driven by strobes from the buffer logic: the total number of bytes held, the number of packets that have been committed, and the number of bytes in the packet that is still being filled. Each cycle it compares the count that the current mode selects against a threshold taken from register fields, either as "at or below" or as "at or above", and registers the result as the flag.

For a buffer that drains toward the external reader (OUT), the compared count is the total byte count, and the threshold is the low byte field joined with a configurable number of upper bits. For a buffer filled by the external writer (IN), the upper bits change role. In the whole-buffer mode they become a packet count, and the pair (committed packets, current bytes) is compared against (packet threshold, byte threshold) in lexicographic order. In the current-packet mode only the bytes of the open packet are compared against the low byte field, and the upper bits are ignored.

Top module: `pkt_level_flag`

## Requirements
- R1: While reset is asserted and in the cycle after its release, all three counts are zero and `flag` is 1. This matches the reset configuration: comparison at-or-above, whole-buffer mode, zero threshold.
- R2: With `is_in`=0, the compared count is the total byte count and the threshold is `{thr_hi[HI_USED-1:0], thr_lo}`. Upper bits of `thr_hi` beyond HI_USED and the `pkt_only` input have no effect.
- R3: With `dir_ge`=0, `flag` is 1 when the count is less than or equal to the threshold. With `dir_ge`=1, `flag` is 1 when the count is greater than or equal to the threshold.
- R4: With `is_in`=1 and `pkt_only`=0, the pair (committed packets, current bytes) is compared lexicographically against (`thr_hi`, `thr_lo`). Packets are compared first, and bytes are compared only when the packet counts are equal.
- R5: In the mode of R4, `thr_hi` values 5, 6 and 7 act as a threshold of 4 packets.
- R6: With `is_in`=1 and `pkt_only`=1, only the current-packet byte count is compared against `thr_lo`, and `thr_hi` has no effect.
- R7: A `commit_stb` adds one committed packet, saturating at 2^PKT_W-1. It also clears the current-packet count to 0, or to 1 if a byte write is accepted in the same cycle.
- R8: A `rel_stb` removes one committed packet and is ignored when there are none. Commit and release in the same cycle leave the packet count unchanged.
- R9: A write strobe adds one byte to the total and is ignored when the total is at 2^BYTE_W-1. A read strobe removes one byte and is ignored at zero. Both strobes together leave the total unchanged, and that write still counts into the current packet. The current count saturates at 2^BYTE_W-1.
- R10: `flag` is registered. A strobe at clock edge k changes the counts at edge k, and the flag reflects them at edge k+1. A threshold or mode change is reflected at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One byte written into the buffer |
| rd_stb | input | 1 | One byte read out of the buffer |
| commit_stb | input | 1 | Close the open packet and count it as committed |
| rel_stb | input | 1 | One committed packet has left the buffer |
| is_in | input | 1 | 1: buffer filled by the external side (IN); 0: drained by it (OUT) |
| dir_ge | input | 1 | 1: flag on count at or above threshold; 0: at or below |
| pkt_only | input | 1 | IN only: 1 compares current-packet bytes only |
| thr_hi | input | HI_W | Upper threshold bits (OUT) or packet threshold (IN) |
| thr_lo | input | LO_W | Low byte threshold field |
| flag | output | 1 | Registered programmable-level flag |

## Verification
The bench uses BYTE_W=6, PKT_W=3, LO_W=3, HI_W=3 and HI_USED=2. With these values the byte total can be driven into both saturation limits in under a hundred strobes, and the packet count can be saturated at 7 above the capped threshold of 4. The threshold space of 8x8 field values is small enough that, after each reached count state, every threshold is swept for both directions, both modes and both polarities. The unused third upper bit in OUT mode and the reserved packet encodings 5 to 7 fall inside every sweep.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    // packet threshold values above this act as this value
    localparam int unsigned PKT_THR_CAP = 4;

    typedef enum logic {
        CMP_AT_OR_BELOW = 1'b0,
        CMP_AT_OR_ABOVE = 1'b1
    } cmp_dir_e;

endpackage

// File: rtl/pflag_counters.sv
module pflag_counters #(
    parameter int BYTE_W = 13,
    parameter int PKT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              commit_stb,
    input  logic              rel_stb,
    output logic [BYTE_W-1:0] total_o,
    output logic [PKT_W-1:0]  pkts_o,
    output logic [BYTE_W-1:0] cur_o
);

    localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
    localparam logic [PKT_W-1:0]  PKT_MAX  = {PKT_W{1'b1}};

    typedef struct packed {
        logic [BYTE_W-1:0] total;
        logic [PKT_W-1:0]  pkts;
        logic [BYTE_W-1:0] cur;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic wr_acc;

    always_comb begin
        cnt_d  = cnt_q;
        wr_acc = wr_stb && (rd_stb || (cnt_q.total != BYTE_MAX));

        // total byte count
        if (wr_stb && !rd_stb) begin
            if (cnt_q.total != BYTE_MAX) cnt_d.total = cnt_q.total + 1'b1;
        end else if (rd_stb && !wr_stb) begin
            if (cnt_q.total != '0) cnt_d.total = cnt_q.total - 1'b1;
        end

        // open packet byte count
        if (commit_stb) begin
            cnt_d.cur = {{(BYTE_W-1){1'b0}}, wr_acc};
        end else if (wr_acc && (cnt_q.cur != BYTE_MAX)) begin
            cnt_d.cur = cnt_q.cur + 1'b1;
        end

        // committed packet count
        if (commit_stb && !rel_stb) begin
            if (cnt_q.pkts != PKT_MAX) cnt_d.pkts = cnt_q.pkts + 1'b1;
        end else if (rel_stb && !commit_stb) begin
            if (cnt_q.pkts != '0) cnt_d.pkts = cnt_q.pkts - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign total_o = cnt_q.total;
    assign pkts_o  = cnt_q.pkts;
    assign cur_o   = cnt_q.cur;

    // R9
    rd_at_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && total_o == '0) |=> (total_o == '0));

    // R9
    wr_rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> $stable(total_o));

    // R7
    commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> (cur_o <= BYTE_W'(1)));

    // R8
    rel_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_stb && !commit_stb && pkts_o == '0) |=> (pkts_o == '0));

endmodule

// File: rtl/pflag_compare.sv
module pflag_compare
    import pflag_pkg::*;
#(
    parameter int BYTE_W  = 13,
    parameter int PKT_W   = 4,
    parameter int LO_W    = 10,
    parameter int HI_W    = 3,
    parameter int HI_USED = 3
) (
    input  logic              is_in,
    input  cmp_dir_e          dir,
    input  logic              pkt_only,
    input  logic [HI_W-1:0]   thr_hi,
    input  logic [LO_W-1:0]   thr_lo,
    input  logic [BYTE_W-1:0] total,
    input  logic [PKT_W-1:0]  pkts,
    input  logic [BYTE_W-1:0] cur,
    output logic              hit
);

    localparam int PW = (PKT_W > HI_W) ? PKT_W : HI_W;

    logic [BYTE_W-1:0] out_thr;
    logic [BYTE_W-1:0] lo_ext;
    logic [HI_W-1:0]   pkt_thr;
    logic [PW-1:0]     pkts_ext, pkt_thr_ext;

    // OUT threshold: low field alone or joined with HI_USED upper bits
    generate
        if (HI_USED == 0) begin : g_out_lo_only
            assign out_thr = BYTE_W'(thr_lo);
        end else begin : g_out_joined
            assign out_thr = BYTE_W'({thr_hi[HI_USED-1:0], thr_lo});
        end
    endgenerate

    assign lo_ext      = BYTE_W'(thr_lo);
    assign pkt_thr     = (thr_hi > HI_W'(PKT_THR_CAP)) ? HI_W'(PKT_THR_CAP) : thr_hi;
    assign pkts_ext    = PW'(pkts);
    assign pkt_thr_ext = PW'(pkt_thr);

    logic above, equal;

    always_comb begin
        if (!is_in) begin
            above = total > out_thr;
            equal = total == out_thr;
        end else if (pkt_only) begin
            above = cur > lo_ext;
            equal = cur == lo_ext;
        end else begin
            above = (pkts_ext > pkt_thr_ext) ||
                    ((pkts_ext == pkt_thr_ext) && (cur > lo_ext));
            equal = (pkts_ext == pkt_thr_ext) && (cur == lo_ext);
        end
        hit = (dir == CMP_AT_OR_ABOVE) ? (above || equal) : !above;
    end

endmodule

// File: rtl/pkt_level_flag.sv
module pkt_level_flag
    import pflag_pkg::*;
#(
    parameter int BYTE_W  = 13,
    parameter int PKT_W   = 4,
    parameter int LO_W    = 10,
    parameter int HI_W    = 3,
    parameter int HI_USED = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic            commit_stb,
    input  logic            rel_stb,
    input  logic            is_in,
    input  logic            dir_ge,
    input  logic            pkt_only,
    input  logic [HI_W-1:0] thr_hi,
    input  logic [LO_W-1:0] thr_lo,
    output logic            flag
);

    logic [BYTE_W-1:0] total, cur;
    logic [PKT_W-1:0]  pkts;
    logic              hit;
    cmp_dir_e          dir;

    assign dir = dir_ge ? CMP_AT_OR_ABOVE : CMP_AT_OR_BELOW;

    pflag_counters #(
        .BYTE_W (BYTE_W),
        .PKT_W  (PKT_W)
    ) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .commit_stb (commit_stb),
        .rel_stb    (rel_stb),
        .total_o    (total),
        .pkts_o     (pkts),
        .cur_o      (cur)
    );

    pflag_compare #(
        .BYTE_W  (BYTE_W),
        .PKT_W   (PKT_W),
        .LO_W    (LO_W),
        .HI_W    (HI_W),
        .HI_USED (HI_USED)
    ) u_compare (
        .is_in    (is_in),
        .dir      (dir),
        .pkt_only (pkt_only),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .total    (total),
        .pkts     (pkts),
        .cur      (cur),
        .hit      (hit)
    );

    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = hit;
    end

    // reset value matches the reset configuration: at-or-above a zero threshold
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{flag: 1'b1};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R6
    cur_only_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_in && pkt_only && dir_ge && (cur >= BYTE_W'(thr_lo))) |=> flag);

    // R2
    out_empty_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_in && !dir_ge && (total == '0)) |=> flag);

    // R4
    in_pkts_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_in && !pkt_only && dir_ge && (pkts > PKT_W'(PKT_THR_CAP))) |=> flag);

endmodule

// File: tb/tb_pkt_level_flag.sv
`timescale 1ns/1ps
module tb_pkt_level_flag;

    localparam int BYTE_W  = 6;
    localparam int PKT_W   = 3;
    localparam int LO_W    = 3;
    localparam int HI_W    = 3;
    localparam int HI_USED = 2;
    localparam int TOT_MAX = (1 << BYTE_W) - 1;
    localparam int PKT_MAX = (1 << PKT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0, rd_stb = 1'b0, commit_stb = 1'b0, rel_stb = 1'b0;
    logic is_in = 1'b0, dir_ge = 1'b1, pkt_only = 1'b0;
    logic [HI_W-1:0] thr_hi = '0;
    logic [LO_W-1:0] thr_lo = '0;
    logic flag;

    always #2.5 clk = ~clk;

    pkt_level_flag #(
        .BYTE_W (BYTE_W), .PKT_W (PKT_W), .LO_W (LO_W),
        .HI_W (HI_W), .HI_USED (HI_USED)
    ) dut (
        .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .rd_stb (rd_stb),
        .commit_stb (commit_stb), .rel_stb (rel_stb), .is_in (is_in),
        .dir_ge (dir_ge), .pkt_only (pkt_only), .thr_hi (thr_hi),
        .thr_lo (thr_lo), .flag (flag)
    );

    int n_checks = 0;
    int n_fail = 0;
    int m_tot = 0, m_pkt = 0, m_cur = 0;
    string ctx = "R1";
    bit done = 1'b0;

    function automatic bit exp_flag(int tot, int pkt, int cur, bit in_m,
                                    bit only, bit ge, int hi, int lo);
        bit above, equal;
        int t, p;
        if (!in_m) begin
            t = (hi % (1 << HI_USED)) * (1 << LO_W) + lo;
            above = tot > t; equal = tot == t;
        end else if (only) begin
            above = cur > lo; equal = cur == lo;
        end else begin
            p = (hi > 4) ? 4 : hi;
            above = (pkt > p) || ((pkt == p) && (cur > lo));
            equal = (pkt == p) && (cur == lo);
        end
        return ge ? (above || equal) : !above;
    endfunction

    function automatic string req_of(bit in_m, bit only, int hi);
        if (!in_m)     return "R2,R3";
        else if (only) return "R6,R3";
        else if (hi > 4) return "R5,R3";
        else           return "R4,R3";
    endfunction

    task automatic check(bit act, bit exp, string tag, string info);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag=%0b expected %0b %s", tag, act, exp, info);
        end
    endtask

    // one strobe cycle, model updated from the requirements (R7 R8 R9)
    task automatic op(bit w, bit r, bit c, bit l);
        bit wacc;
        @(negedge clk);
        wr_stb = w; rd_stb = r; commit_stb = c; rel_stb = l;
        wacc = w && (r || (m_tot != TOT_MAX));
        if (w && !r) begin
            if (m_tot < TOT_MAX) m_tot++;
        end else if (r && !w) begin
            if (m_tot > 0) m_tot--;
        end
        if (c) m_cur = wacc ? 1 : 0;
        else if (wacc && m_cur < TOT_MAX) m_cur++;
        if (c && !l) begin
            if (m_pkt < PKT_MAX) m_pkt++;
        end else if (l && !c) begin
            if (m_pkt > 0) m_pkt--;
        end
    endtask

    // all thresholds, modes and polarities against the current counts
    task automatic sweep();
        bit have_prev = 1'b0;
        bit p_in = 1'b0, p_only = 1'b0, p_ge = 1'b0;
        int p_hi = 0, p_lo = 0;
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            wr_stb = 1'b0; rd_stb = 1'b0; commit_stb = 1'b0; rel_stb = 1'b0;
            if (have_prev)
                check(flag, exp_flag(m_tot, m_pkt, m_cur, p_in, p_only, p_ge, p_hi, p_lo),
                      {ctx, " ", req_of(p_in, p_only, p_hi)},
                      $sformatf("(in=%0d only=%0d ge=%0d hi=%0d lo=%0d tot=%0d pkt=%0d cur=%0d)",
                                p_in, p_only, p_ge, p_hi, p_lo, m_tot, m_pkt, m_cur));
            p_lo = k % 8; p_hi = (k / 8) % 8; p_ge = k[6]; p_only = k[7]; p_in = k[8];
            thr_lo = LO_W'(p_lo); thr_hi = HI_W'(p_hi);
            dir_ge = p_ge; pkt_only = p_only; is_in = p_in;
            have_prev = 1'b1;
        end
        @(negedge clk);
        check(flag, exp_flag(m_tot, m_pkt, m_cur, p_in, p_only, p_ge, p_hi, p_lo),
              {ctx, " ", req_of(p_in, p_only, p_hi)}, "(last of sweep)");
    endtask

    initial begin
        logic [15:0] lfsr;
        bit w, r, c, l;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(flag, 1'b1, "R1", "(in reset)");
        rst_n = 1'b1;
        @(negedge clk);
        check(flag, 1'b1, "R1", "(first cycle after reset, default config)");

        // R10: latency, OUT mode, at-or-above threshold 1
        thr_lo = LO_W'(1);
        @(negedge clk);
        check(flag, 1'b0, "R10", "(threshold change seen one edge later)");
        @(negedge clk);
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(flag, 1'b0, "R10", "(flag not yet updated after write edge)");
        @(negedge clk);
        check(flag, 1'b1, "R10", "(flag updated one edge after count)");
        m_tot = 1; m_cur = 1;

        ctx = "R10";
        sweep();

        // R9: fill past full, then drain past empty
        ctx = "R9";
        for (int i = 0; i < 70; i++) op(1'b1, 1'b0, 1'b0, 1'b0);
        sweep();
        op(1'b1, 1'b1, 1'b0, 1'b0);
        sweep();
        for (int i = 0; i < 70; i++) op(1'b0, 1'b1, 1'b0, 1'b0);
        sweep();

        // R7: commits saturate, commit with write
        ctx = "R7";
        for (int i = 0; i < 3; i++) op(1'b1, 1'b0, 1'b0, 1'b0);
        op(1'b1, 1'b0, 1'b1, 1'b0);
        sweep();
        for (int i = 0; i < 10; i++) op(1'b0, 1'b0, 1'b1, 1'b0);
        op(1'b1, 1'b0, 1'b0, 1'b0);
        sweep();

        // R8: releases, simultaneous commit and release
        ctx = "R8";
        for (int i = 0; i < 3; i++) op(1'b0, 1'b0, 1'b0, 1'b1);
        sweep();
        op(1'b1, 1'b0, 1'b1, 1'b1);
        sweep();
        for (int i = 0; i < 10; i++) op(1'b0, 1'b0, 1'b0, 1'b1);
        sweep();

        // mixed traffic
        ctx = "R9";
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 150) begin
                w = lfsr[1] | lfsr[2]; r = lfsr[3] & lfsr[4];
            end else begin
                w = lfsr[1] & lfsr[2]; r = lfsr[3] | lfsr[4];
            end
            c = lfsr[5] & lfsr[6] & lfsr[7];
            l = lfsr[8] & lfsr[9] & lfsr[11];
            op(w, r, c, l);
            if (i % 10 == 9) sweep();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule